// File: doc/BRIEF.md
# Line Parity Error Tally Unit

This block turns the once-per-frame comparison of received line-parity bytes into an error tally. When a frame strobe arrives, the unit XORs the received parity vector with the locally computed parity vector. It counts either every differing bit or at most one error for the whole frame. It then reports the result as a one-clock increment. Signal-degrade and signal-fail detectors downstream consume that increment, so the counting mode steers them as well as the cumulative count.

A saturating cumulative counter adds each increment. Software reads it through a read-and-clear strobe: the strobe copies the count into a snapshot register and restarts the count in the same cycle. The number of parity bytes checked per frame is either three or twelve. Producing the parity, descrambling and framing all happen elsewhere.

Top module: `parity_tally_unit`

## Requirements
- R1: After reset, `inc_valid` is 0, `inc_val` is 0, `err_count` is 0 and `err_snapshot` is 0.
- R2: With `per_frame_mode` = 0 (per-bit counting), the increment equals the number of bit positions where `rx_par` and `calc_par` differ within the checked bytes (at most 96).
- R3: With `per_frame_mode` = 1 (per-frame counting), the increment is 1 if any checked bit differs and 0 otherwise. It is never above 1.
- R4: With `wide_sel` = 0, only bytes 0..2 (bits [23:0]) are checked and bits [95:24] have no effect. With `wide_sel` = 1, all twelve bytes (bits [95:0]) are checked.
- R5: `err_count` advances by `inc_val` on the clock edge that ends the cycle in which `inc_valid` is high. It changes at no other time, apart from a clear.
- R6: `inc_valid` is high for exactly the one clock following each sampled `frame_stb`. `inc_val` is 0 whenever `inc_valid` is low.
- R7: When `rd_clr` is sampled high, `err_snapshot` takes the current `err_count`. `err_count` restarts at 0 plus any increment that is valid in that same cycle.
- R8: `err_count` (CNT_W bits, default 32) saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe: parity vectors are valid |
| wide_sel | input | 1 | 0: check 3 bytes, 1: check 12 bytes |
| per_frame_mode | input | 1 | 0: per-bit tally, 1: per-frame tally |
| rx_par | input | 96 | Received parity bytes, byte b at bits [8b+7:8b] |
| calc_par | input | 96 | Locally computed parity bytes, same layout |
| rd_clr | input | 1 | Read-and-clear strobe for the counter |
| inc_valid | output | 1 | Increment valid, one clock per frame |
| inc_val | output | 7 | Per-frame error increment |
| err_count | output | CNT_W | Saturating cumulative error count |
| err_snapshot | output | CNT_W | Count captured by the last read-and-clear |

## Verification
If the byte mask or the popcount is wrong, the error shows up in `inc_val` one clock after the strobe. It then shows up in `err_count` one clock after that, so the per-cycle reference comparison catches it within two cycles of the faulty frame. If the accumulator adds the wrong value, fails to saturate, or mishandles a clear that coincides with an increment, `err_count` diverges at once. A clear that does not copy the old count makes `err_snapshot` diverge on the edge of the clear. Directed frames with known patterns separate the per-bit and per-frame counting modes and the two byte widths.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  localparam int PTU_BYTE_W       = 8;
  localparam int PTU_NARROW_BYTES = 3;
  localparam int PTU_WIDE_BYTES   = 12;

  typedef enum logic {
    TALLY_PER_BIT   = 1'b0,
    TALLY_PER_FRAME = 1'b1
  } tally_mode_e;
endpackage

// File: rtl/ptu_mismatch.sv
module ptu_mismatch
  import ptu_pkg::*;
#(
  parameter int NUM_BYTES = PTU_WIDE_BYTES,
  parameter int INC_W     = $clog2(NUM_BYTES*PTU_BYTE_W+1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_stb,
  input  logic                          wide_sel,
  input  logic                          per_frame_mode,
  input  logic [NUM_BYTES*PTU_BYTE_W-1:0] rx_par,
  input  logic [NUM_BYTES*PTU_BYTE_W-1:0] calc_par,
  output logic                          inc_valid,
  output logic [INC_W-1:0]              inc_val
);
  localparam int TOT_BITS = NUM_BYTES*PTU_BYTE_W;

  logic [TOT_BITS-1:0] diff_masked;
  logic [INC_W-1:0]    ones;
  logic [INC_W-1:0]    inc_nxt;
  logic                valid_nxt;
  tally_mode_e         mode;

  assign mode = tally_mode_e'(per_frame_mode);

  // per-byte enable: narrow window keeps only the low bytes
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic byte_en;
    assign byte_en = wide_sel || (b < PTU_NARROW_BYTES);
    assign diff_masked[b*PTU_BYTE_W +: PTU_BYTE_W] =
      (rx_par[b*PTU_BYTE_W +: PTU_BYTE_W] ^ calc_par[b*PTU_BYTE_W +: PTU_BYTE_W])
      & {PTU_BYTE_W{byte_en}};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < TOT_BITS; i++) begin
      ones = ones + INC_W'(diff_masked[i]);
    end
  end

  always_comb begin
    valid_nxt = frame_stb;
    inc_nxt   = '0;
    if (frame_stb) begin
      if (mode == TALLY_PER_FRAME) inc_nxt = INC_W'(|diff_masked);
      else                         inc_nxt = ones;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_valid <= 1'b0;
      inc_val   <= '0;
    end else begin
      inc_valid <= valid_nxt;
      inc_val   <= inc_nxt;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_valid |-> inc_val == '0);  // R6
  AST_FRAME_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_stb && per_frame_mode) |-> inc_val <= INC_W'(1));  // R3
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid |-> inc_val <= INC_W'(TOT_BITS));  // R2
  AST_NARROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_stb && !wide_sel) |-> inc_val <= INC_W'(PTU_NARROW_BYTES*PTU_BYTE_W));  // R4
endmodule

// File: rtl/ptu_accum.sv
module ptu_accum #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_valid,
  input  logic [INC_W-1:0] inc_val,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] err_snapshot
);
  localparam logic [CNT_W:0] SAT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             snap_en;

  always_comb begin
    snap_en = rd_clr;
    cnt_en  = rd_clr || inc_valid;
    base    = rd_clr ? '0 : {1'b0, err_count};
    sum     = base + (inc_valid ? (CNT_W+1)'(inc_val) : '0);
    cnt_nxt = (sum > SAT_MAX) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0;
    end else if (cnt_en) begin
      err_count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_snapshot <= '0;
    end else if (snap_en) begin
      err_snapshot <= err_count;
    end
  end

  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr) |-> err_count >= $past(err_count));  // R8
  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr) |-> err_snapshot == $past(err_count));  // R7
  AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_clr && !inc_valid) |-> $stable(err_count));  // R5
endmodule

// File: rtl/parity_tally_unit.sv
module parity_tally_unit
  import ptu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    frame_stb,
  input  logic                                    wide_sel,
  input  logic                                    per_frame_mode,
  input  logic [PTU_WIDE_BYTES*PTU_BYTE_W-1:0]    rx_par,
  input  logic [PTU_WIDE_BYTES*PTU_BYTE_W-1:0]    calc_par,
  input  logic                                    rd_clr,
  output logic                                    inc_valid,
  output logic [$clog2(PTU_WIDE_BYTES*PTU_BYTE_W+1)-1:0] inc_val,
  output logic [CNT_W-1:0]                        err_count,
  output logic [CNT_W-1:0]                        err_snapshot
);
  localparam int INC_W = $clog2(PTU_WIDE_BYTES*PTU_BYTE_W+1);

  ptu_mismatch #(.NUM_BYTES(PTU_WIDE_BYTES), .INC_W(INC_W)) u_mismatch (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_stb      (frame_stb),
    .wide_sel       (wide_sel),
    .per_frame_mode (per_frame_mode),
    .rx_par         (rx_par),
    .calc_par       (calc_par),
    .inc_valid      (inc_valid),
    .inc_val        (inc_val)
  );

  ptu_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc_valid    (inc_valid),
    .inc_val      (inc_val),
    .rd_clr       (rd_clr),
    .err_count    (err_count),
    .err_snapshot (err_snapshot)
  );

  AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid |-> $past(frame_stb));  // R6
endmodule

// File: tb/parity_tally_unit_tb.sv
module parity_tally_unit_tb;
  localparam int PERIOD = 10;
  localparam int CW     = 8;
  localparam longint CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0, wide_sel = 1'b0, per_frame_mode = 1'b0, rd_clr = 1'b0;
  logic [95:0] rx_par = '0, calc_par = '0;
  logic inc_valid;
  logic [6:0] inc_val;
  logic [CW-1:0] err_count, err_snapshot;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  parity_tally_unit #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .wide_sel(wide_sel),
    .per_frame_mode(per_frame_mode), .rx_par(rx_par), .calc_par(calc_par),
    .rd_clr(rd_clr), .inc_valid(inc_valid), .inc_val(inc_val),
    .err_count(err_count), .err_snapshot(err_snapshot));

  function automatic int ref_inc(logic [95:0] a, logic [95:0] b, bit wide, bit pf);
    int n = 0;
    int nbytes = wide ? 12 : 3;
    for (int i = 0; i < nbytes*8; i++) if (a[i] != b[i]) n++;
    if (pf) return (n > 0) ? 1 : 0;
    return n;
  endfunction

  // behavioural reference model
  int     m_inc = 0;
  bit     m_v = 0;
  longint m_cnt = 0, m_snap = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_inc = 0; m_v = 0; m_cnt = 0; m_snap = 0;
    end else begin
      longint nc;
      if (rd_clr) begin
        m_snap = m_cnt;
        nc = 0;
      end else nc = m_cnt;
      if (m_v) nc = nc + m_inc;
      m_cnt = (nc > CMAX) ? CMAX : nc;
      m_v   = frame_stb;
      m_inc = frame_stb ? ref_inc(rx_par, calc_par, wide_sel, per_frame_mode) : 0;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 inc_valid", inc_valid, m_v);
    chk(per_frame_mode ? "R3 inc_val" : "R2 inc_val", inc_val, m_inc);
    chk("R5 err_count", err_count, m_cnt);
    chk("R7 err_snapshot", err_snapshot, m_snap);
  end

  // drive one frame; return with the increment visible
  task automatic frame(logic [95:0] rx, logic [95:0] cx, bit wide, bit pf);
    @(negedge clk);
    rx_par = rx; calc_par = cx; wide_sel = wide; per_frame_mode = pf; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); rd_clr = 1'b1;
    @(negedge clk); rd_clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 inc_valid", inc_valid, 0);
    chk("R1 err_count", err_count, 0);
    chk("R1 err_snapshot", err_snapshot, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 inc_val", inc_val, 0);

    // R2: per-bit narrow, 8 bits differ in byte 1
    frame(96'h0, 96'h00FF00, 1'b0, 1'b0);
    chk("R2 narrow per-bit", inc_val, 8);
    // R2: per-bit wide, all bits differ
    frame('0, '1, 1'b1, 1'b0);
    chk("R2 wide per-bit max", inc_val, 96);
    @(negedge clk);
    chk("R6 valid drops", inc_valid, 0);
    chk("R5 count after two frames", err_count, 104);
    // R3: per-frame
    frame('0, '1, 1'b1, 1'b1);
    chk("R3 per-frame any", inc_val, 1);
    frame(96'h5, 96'h5, 1'b1, 1'b1);
    chk("R3 per-frame none", inc_val, 0);
    // R4: narrow ignores upper bytes
    frame(96'h0, {72'hFFFF, 24'h0}, 1'b0, 1'b0);
    chk("R4 narrow ignores high", inc_val, 0);
    frame(96'h0, {72'h1, 24'h0}, 1'b1, 1'b0);
    chk("R4 wide sees byte3", inc_val, 1);
    @(negedge clk);
    chk("R5 count", err_count, 106);
    // R7: clear with no increment
    clear();
    chk("R7 snapshot", err_snapshot, 106);
    chk("R7 zeroed", err_count, 0);
    // R7: clear coincides with valid increment
    @(negedge clk);
    rx_par = '0; calc_par = 96'hF; wide_sel = 0; per_frame_mode = 0; frame_stb = 1;
    @(negedge clk); frame_stb = 0; rd_clr = 1;
    @(negedge clk); rd_clr = 0;
    chk("R7 fresh count keeps inc", err_count, 4);
    // R8: saturation
    for (int k = 0; k < 3; k++) frame('0, '1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 saturate", err_count, CMAX);
    frame('0, '1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 stays saturated", err_count, CMAX);
    clear();
    // random mix
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      rx_par = {$urandom, $urandom, $urandom};
      calc_par = ($urandom_range(0,3) == 0) ? rx_par : rx_par ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
      wide_sel = $urandom_range(0,1);
      per_frame_mode = $urandom_range(0,1);
      frame_stb = $urandom_range(0,1);
      rd_clr = ($urandom_range(0,9) == 0);
    end
    @(negedge clk); frame_stb = 0; rd_clr = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule